// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block derives all digital drive clocks for a two-channel linear CCD sensor from a fast system clock. A start pulse begins a line. The block first produces a transfer-gate pulse, framed by a settle margin before it and a hold margin after it. It then clocks the whole line out: odd pixels on channel 1 and even pixels on channel 2. Each channel has its own phase-1, phase-2, last-stage shift clock, reset-gate pulse and reset-level clamp pulse.

Every width and delay is a configuration input counted in system clock cycles. The block latches these inputs, together with the clamp mode and the channel phase mode, when it accepts a start. For each pixel it reads, each channel also presents a strobe, the pixel's position in the line and a class tag, so that capture logic downstream knows what it is sampling.

Top module: `ccd_drive_gen`

## Requirements
- R1: A line holds N_DUMMY dummy, N_OB optical black, N_LEAD invalid, N_VALID valid and N_TRAIL invalid cells, in that order, with 0-based positions 0..N_PIX-1. Channel 1 carries the even positions and channel 2 the odd ones, N_PIX/2 on each. The class tag is 0 for dummy, 1 for optical black, 2 for invalid and 3 for valid.
- R2: After a start is accepted, the transfer gate rises after max(tg_pre_i,1) cycles. It stays high for tg_w_i cycles, limited to the range TG_MIN..TG_MAX. Reading begins max(tg_post_i,POST_MIN) cycles after the gate falls. Whenever a channel is not reading, its phase-1 clock is high and its phase-2 and last-stage clocks are low.
- R3: The reset and clamp outputs of both channels are low whenever that channel is not reading. This covers the whole gate pulse and both of its margins.
- R4: While a channel is reading, cycle s (0..L-1) of each pixel period drives phase-1 high when s < L/2 (rounded down). Phase-2 and last-stage are the complement of phase-1.
- R5: The reset pulse is high in cycles s < max(rst_w_i,RST_MIN) of each pixel period.
- R6: In bit clamp mode (line_clamp_i=0), the clamp pulse is high in cycles s with W+D <= s < W+D+cp_w_i. Here W is the reset width and D = max(cp_dly_i,CPD_MIN). The pulse is cut off at the end of the pixel period.
- R7: In line clamp mode (line_clamp_i=1), the clamp outputs stay low for the whole line.
- R8: In in-phase mode (split_i=0), the two channels produce identical clocks and strobes. In split mode, channel 2 runs exactly L/2 cycles (rounded down) later than channel 1.
- R9: The pixel period L is max(pix_len_i,PIX_MIN) cycles, which keeps each channel's pixel rate within its limit.
- R10: Each channel raises its strobe for one cycle in the last cycle of each pixel period, and the position and tag outputs belong to that pixel.
- R11: Configuration inputs are sampled only when a start is accepted. Changes to them during a line have no effect, and a start while busy is ignored.
- R12: Busy is low after reset and rises in the cycle after a start is accepted. It stays high until the cycle after the last strobe of the line and falls one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a line when idle |
| line_clamp_i | input | 1 | 1 selects line clamp, 0 selects bit clamp |
| split_i | input | 1 | 1 offsets channel 2 by half a pixel period |
| pix_len_i | input | CW | Pixel period in cycles |
| rst_w_i | input | CW | Reset pulse width in cycles |
| cp_dly_i | input | CW | Gap from reset end to clamp start |
| cp_w_i | input | CW | Clamp pulse width in cycles |
| tg_pre_i | input | CW | Settle margin before the gate |
| tg_w_i | input | TW | Gate pulse width |
| tg_post_i | input | TW | Hold margin after the gate |
| busy_o | output | 1 | Line in progress |
| tg_o | output | 1 | Transfer gate pulse |
| phi1_o | output | 2 | Phase-1 shift clock, bit 0 is channel 1 |
| phi2_o | output | 2 | Phase-2 shift clock |
| phil_o | output | 2 | Last-stage shift clock |
| rs_o | output | 2 | Reset gate pulse |
| cp_o | output | 2 | Reset-level clamp pulse |
| strb_o | output | 2 | Per-pixel sample strobe |
| ch1_idx_o | output | IDX_W | Channel 1 pixel position |
| ch1_cls_o | output | 2 | Channel 1 class tag |
| ch2_idx_o | output | IDX_W | Channel 2 pixel position |
| ch2_cls_o | output | 2 | Channel 2 class tag |

## Verification
Call k+1 the cycle in which a start is sampled. The gate is then due at k+1+pre and reading at E = k+1+pre+tg+post. The strobe for pixel pair p on channel c is due at E+off_c+p*L+L-1, and busy falls two cycles after the last strobe. The driver pushes each strobe into the scoreboard with its due cycle and computes a golden waveform for every clock line. On each falling edge, the monitor compares the outputs against the golden waveform and against the head of the queue, so any early, late or missing result is seen at the exact cycle.

// File: rtl/ccd_drive_gen.sv
module ccd_drive_gen #(
  parameter int N_DUMMY  = 32,
  parameter int N_OB     = 96,
  parameter int N_LEAD   = 6,
  parameter int N_VALID  = 7400,
  parameter int N_TRAIL  = 6,
  parameter int IDX_W    = 13,
  parameter int CW       = 8,
  parameter int TW       = 16,
  parameter int PIX_MIN  = 5,
  parameter int TG_MIN   = 100,
  parameter int TG_MAX   = 1000,
  parameter int POST_MIN = 20,
  parameter int RST_MIN  = 1,
  parameter int CPD_MIN  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             line_clamp_i,
  input  logic             split_i,
  input  logic [CW-1:0]    pix_len_i,
  input  logic [CW-1:0]    rst_w_i,
  input  logic [CW-1:0]    cp_dly_i,
  input  logic [CW-1:0]    cp_w_i,
  input  logic [CW-1:0]    tg_pre_i,
  input  logic [TW-1:0]    tg_w_i,
  input  logic [TW-1:0]    tg_post_i,
  output logic             busy_o,
  output logic             tg_o,
  output logic [1:0]       phi1_o,
  output logic [1:0]       phi2_o,
  output logic [1:0]       phil_o,
  output logic [1:0]       rs_o,
  output logic [1:0]       cp_o,
  output logic [1:0]       strb_o,
  output logic [IDX_W-1:0] ch1_idx_o,
  output logic [1:0]       ch1_cls_o,
  output logic [IDX_W-1:0] ch2_idx_o,
  output logic [1:0]       ch2_cls_o
);
  localparam int N_PIX   = N_DUMMY + N_OB + N_LEAD + N_VALID + N_TRAIL;
  localparam int NP      = N_PIX / 2;
  localparam int EW      = CW + 2;
  localparam int B_OB    = N_DUMMY;
  localparam int B_LEAD  = B_OB + N_OB;
  localparam int B_VAL   = B_LEAD + N_LEAD;
  localparam int B_TRAIL = B_VAL + N_VALID;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_GATE, S_POST, S_READ} st_t;
  st_t st;

  logic [TW-1:0] cnt, cur_len;
  logic [CW-1:0] s_pix, s_rw, s_cd, s_cw, s_pre;
  logic [TW-1:0] s_tg, s_post;
  logic          s_line, s_split;
  logic [1:0]    idle_v;
  logic [1:0][IDX_W-1:0] idx_a;
  logic [1:0][1:0]       cls_a;

  always_comb
    case (st)
      S_PRE:   cur_len = TW'(s_pre);
      S_GATE:  cur_len = s_tg;
      default: cur_len = s_post;
    endcase

  wire seg_end = (cnt == cur_len - TW'(1));
  wire go      = (st == S_POST) && seg_end;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      s_pix   <= CW'(PIX_MIN);
      s_rw    <= CW'(RST_MIN);
      s_cd    <= CW'(CPD_MIN);
      s_cw    <= '0;
      s_pre   <= CW'(1);
      s_tg    <= TW'(TG_MIN);
      s_post  <= TW'(POST_MIN);
      s_line  <= 1'b0;
      s_split <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          st      <= S_PRE;
          cnt     <= '0;
          s_pix   <= (pix_len_i < CW'(PIX_MIN)) ? CW'(PIX_MIN) : pix_len_i;
          s_rw    <= (rst_w_i < CW'(RST_MIN)) ? CW'(RST_MIN) : rst_w_i;
          s_cd    <= (cp_dly_i < CW'(CPD_MIN)) ? CW'(CPD_MIN) : cp_dly_i;
          s_cw    <= cp_w_i;
          s_pre   <= (tg_pre_i == '0) ? CW'(1) : tg_pre_i;
          s_tg    <= (tg_w_i < TW'(TG_MIN)) ? TW'(TG_MIN) :
                     (tg_w_i > TW'(TG_MAX)) ? TW'(TG_MAX) : tg_w_i;
          s_post  <= (tg_post_i < TW'(POST_MIN)) ? TW'(POST_MIN) : tg_post_i;
          s_line  <= line_clamp_i;
          s_split <= split_i;
        end
        S_PRE, S_GATE, S_POST:
          if (seg_end) begin
            cnt <= '0;
            if (st == S_PRE)       st <= S_GATE;
            else if (st == S_GATE) st <= S_POST;
            else                   st <= S_READ;
          end else cnt <= cnt + TW'(1);
        S_READ: if (&idle_v) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end

  assign busy_o = (st != S_IDLE);
  assign tg_o   = (st == S_GATE);

  for (genvar c = 0; c < 2; c++) begin : g_ch
    logic             act, pend;
    logic [CW-1:0]    sub, dl;
    logic [IDX_W-1:0] pr, idx;
    logic [1:0]       cls;
    wire [CW-1:0] half = s_pix >> 1;
    wire [CW-1:0] off  = (c == 0 || !s_split) ? '0 : half;
    wire          lo   = sub < half;
    wire          last = (sub == s_pix - CW'(1));
    wire [EW-1:0] cp_a = EW'(s_rw) + EW'(s_cd);
    wire [EW-1:0] cp_b = cp_a + EW'(s_cw);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        act <= 1'b0; pend <= 1'b0; sub <= '0; dl <= '0; pr <= '0;
      end else if (go) begin
        sub <= '0;
        pr  <= '0;
        if (off == '0) act <= 1'b1;
        else begin pend <= 1'b1; dl <= off - CW'(1); end
      end else if (pend) begin
        if (dl == '0) begin pend <= 1'b0; act <= 1'b1; end
        else dl <= dl - CW'(1);
      end else if (act) begin
        if (last) begin
          sub <= '0;
          if (pr == IDX_W'(NP - 1)) act <= 1'b0;
          else pr <= pr + IDX_W'(1);
        end else sub <= sub + CW'(1);
      end

    assign idx = pr + pr + IDX_W'(c);
    always_comb
      if (idx < IDX_W'(B_OB))         cls = 2'd0;
      else if (idx < IDX_W'(B_LEAD))  cls = 2'd1;
      else if (idx < IDX_W'(B_VAL))   cls = 2'd2;
      else if (idx < IDX_W'(B_TRAIL)) cls = 2'd3;
      else                            cls = 2'd2;

    assign phi1_o[c] = !act || lo;
    assign phi2_o[c] = act && !lo;
    assign phil_o[c] = act && !lo;
    assign rs_o[c]   = act && (sub < s_rw);
    assign cp_o[c]   = act && !s_line && (EW'(sub) >= cp_a) && (EW'(sub) < cp_b);
    assign strb_o[c] = act && last;
    assign idle_v[c] = !act && !pend;
    assign idx_a[c]  = idx;
    assign cls_a[c]  = cls;
  end

  assign ch1_idx_o = idx_a[0];
  assign ch1_cls_o = cls_a[0];
  assign ch2_idx_o = idx_a[1];
  assign ch2_cls_o = cls_a[1];

  a_r3_quiet_gate: assert property (@(posedge clk) disable iff (!rst_n)
    tg_o |-> (rs_o == 2'b00 && cp_o == 2'b00));
  a_r2_clocks_parked: assert property (@(posedge clk) disable iff (!rst_n)
    tg_o |-> (phi1_o == 2'b11 && phi2_o == 2'b00 && phil_o == 2'b00));
  a_r7_line_clamp_low: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && s_line) |-> (cp_o == 2'b00));
  a_r8_inphase_match: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !s_split) |-> (phi1_o[0] == phi1_o[1] && rs_o[0] == rs_o[1] &&
                              cp_o[0] == cp_o[1] && strb_o[0] == strb_o[1]));
  a_r12_busy_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_o != 2'b00) |-> busy_o);
endmodule

// File: tb/ccd_drive_gen_tb.sv
module ccd_drive_gen_tb;
  localparam int ND = 4, NO = 4, NL = 2, NV = 10, NT = 2;
  localparam int NPIX = ND + NO + NL + NV + NT;
  localparam int NP = NPIX / 2;

  typedef struct { int cyc; int ch; int idx; int cls; } item_t;
  item_t q[$];

  logic clk = 0, rst_n = 0, start = 0, linec = 0, split = 0;
  logic [7:0] pix = 8, rw = 2, cd = 1, cw = 2, pre = 1;
  logic [15:0] tw = 120, post = 20;
  logic busy, tg;
  logic [1:0] phi1, phi2, phil, rs, cp, strb;
  logic [12:0] idx1, idx2;
  logic [1:0] cls1, cls2;

  int total = 0, bad = 0, cyc = 0;
  int line_valid = 0, m_S, m_tg0, m_tg1, m_e0, m_off2, m_L, m_rw, m_cd, m_cw, m_bit, m_split, m_end;

  ccd_drive_gen #(.N_DUMMY(ND), .N_OB(NO), .N_LEAD(NL), .N_VALID(NV), .N_TRAIL(NT)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .line_clamp_i(linec), .split_i(split),
    .pix_len_i(pix), .rst_w_i(rw), .cp_dly_i(cd), .cp_w_i(cw), .tg_pre_i(pre),
    .tg_w_i(tw), .tg_post_i(post), .busy_o(busy), .tg_o(tg), .phi1_o(phi1),
    .phi2_o(phi2), .phil_o(phil), .rs_o(rs), .cp_o(cp), .strb_o(strb),
    .ch1_idx_o(idx1), .ch1_cls_o(cls1), .ch2_idx_o(idx2), .ch2_cls_o(cls2));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int cls_of(int i);
    if (i < ND) return 0;
    if (i < ND + NO) return 1;
    if (i < ND + NO + NL) return 2;
    if (i < ND + NO + NL + NV) return 3;
    return 2;
  endfunction

  task automatic chk(input int act, input int exp, input string req, input string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s cyc=%0d actual=%0d expected=%0d", req, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(int'(tg), int'(line_valid != 0 && cyc >= m_tg0 && cyc < m_tg1), "R2", "tg");
    chk(int'(busy), int'(line_valid != 0 && cyc >= m_S && cyc <= m_end), "R12", "busy");
    for (int ch = 0; ch < 2; ch++) begin
      int st, en, s, inw, e1;
      string rp, rr, rc;
      st  = m_e0 + (ch == 1 ? m_off2 : 0);
      en  = st + NP * m_L;
      inw = (line_valid != 0 && cyc >= st && cyc < en) ? 1 : 0;
      s   = inw ? (cyc - st) % m_L : 0;
      e1  = (!inw || s < m_L / 2) ? 1 : 0;
      rp  = !inw ? "R2" : (ch == 1 && m_split != 0) ? "R8" : "R4";
      rr  = !inw ? "R3" : (ch == 1 && m_split != 0) ? "R8" : "R5";
      rc  = !inw ? "R3" : (m_bit != 0) ? "R6" : "R7";
      chk(int'(phi1[ch]), e1, rp, ch ? "phi1 ch2" : "phi1 ch1");
      chk(int'(phi2[ch]), 1 - e1, rp, ch ? "phi2 ch2" : "phi2 ch1");
      chk(int'(phil[ch]), 1 - e1, rp, ch ? "last ch2" : "last ch1");
      chk(int'(rs[ch]), int'(inw != 0 && s < m_rw), rr, ch ? "reset ch2" : "reset ch1");
      chk(int'(cp[ch]), int'(inw != 0 && m_bit != 0 && s >= m_rw + m_cd && s < m_rw + m_cd + m_cw),
          rc, ch ? "clamp ch2" : "clamp ch1");
    end
    while (q.size() > 0 && q[0].cyc < cyc) begin
      total++; bad++;
      $display("FAIL R10 missing strobe ch%0d actual=none expected=cyc %0d", q[0].ch + 1, q[0].cyc);
      void'(q.pop_front());
    end
    for (int ch = 0; ch < 2; ch++) if (strb[ch]) begin
      if (q.size() == 0) begin
        total++; bad++;
        $display("FAIL R10 stray strobe ch%0d cyc=%0d actual=1 expected=0", ch + 1, cyc);
      end else begin
        item_t it;
        it = q.pop_front();
        chk(cyc, it.cyc, "R10", "strobe cycle");
        chk(ch, it.ch, "R10", "strobe channel");
        chk(ch ? int'(idx2) : int'(idx1), it.idx, "R1", "pixel position");
        chk(ch ? int'(cls2) : int'(cls1), it.cls, "R1", "class tag");
      end
    end
  end

  task automatic run_line(input int p_pix, input int p_rw, input int p_cd, input int p_cw,
                          input int p_pre, input int p_tw, input int p_post,
                          input bit p_line, input bit p_split, input bit poke);
    int k, L, twe;
    @(negedge clk);
    pix = 8'(p_pix); rw = 8'(p_rw); cd = 8'(p_cd); cw = 8'(p_cw); pre = 8'(p_pre);
    tw = 16'(p_tw); post = 16'(p_post); linec = p_line; split = p_split; start = 1;
    k   = cyc;
    L   = p_pix < 5 ? 5 : p_pix;
    twe = p_tw < 100 ? 100 : (p_tw > 1000 ? 1000 : p_tw);
    m_S = k + 1;
    m_tg0 = m_S + (p_pre < 1 ? 1 : p_pre);
    m_tg1 = m_tg0 + twe;
    m_e0 = m_tg1 + (p_post < 20 ? 20 : p_post);
    m_L = L; m_rw = p_rw < 1 ? 1 : p_rw; m_cd = p_cd < 1 ? 1 : p_cd; m_cw = p_cw;
    m_bit = p_line ? 0 : 1; m_split = p_split ? 1 : 0;
    m_off2 = p_split ? L / 2 : 0;
    m_end = m_e0 + m_off2 + NP * L;
    for (int p = 0; p < NP; p++)
      for (int ch = 0; ch < 2; ch++) begin
        item_t it;
        it.cyc = m_e0 + (ch ? m_off2 : 0) + p * L + L - 1;
        it.ch = ch; it.idx = 2 * p + ch; it.cls = cls_of(2 * p + ch);
        q.push_back(it);
      end
    line_valid = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      // R11: new settings and a second start mid-line must change nothing
      while (cyc < m_e0 + 3) @(negedge clk);
      pix = 20; rw = 9; cd = 4; cw = 1; tw = 900; post = 60;
      linec = ~linec; split = ~split; start = 1;
      repeat (3) @(negedge clk);
      start = 0;
    end
    while (cyc <= m_end + 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 / R3 / R2: state held by reset
    chk(int'(busy), 0, "R12", "busy in reset");
    chk(int'(tg), 0, "R2", "tg in reset");
    chk(int'(phi1), 3, "R2", "phi1 in reset");
    chk(int'(phi2 | phil), 0, "R2", "phi2/last in reset");
    chk(int'(rs | cp), 0, "R3", "reset/clamp in reset");
    chk(int'(strb), 0, "R10", "strobe in reset");
    rst_n = 1;
    repeat (2) @(negedge clk);
    run_line(8, 2, 1, 2, 3, 120, 25, 0, 0, 0);    // R1 R4 R5 R6 bit clamp, in phase
    run_line(9, 2, 2, 3, 2, 150, 30, 0, 1, 0);    // R8 split, odd period
    run_line(10, 3, 1, 2, 4, 200, 40, 1, 1, 0);   // R7 line clamp
    run_line(2, 0, 0, 1, 0, 50, 5, 0, 0, 0);      // R9 R2 lower limits
    run_line(6, 1, 1, 2, 1, 3000, 22, 0, 0, 0);   // R2 gate width cap
    run_line(7, 3, 2, 10, 2, 110, 20, 0, 1, 1);   // R6 clipped clamp, R11 poke
    run_line(12, 4, 2, 3, 5, 130, 21, 0, 0, 0);   // R6 R5 wider pulses
    chk(q.size(), 0, "R10", "strobes left over");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule